// File: doc/BRIEF.md
# SD Card Clock Divider and Gate

This block makes the clock that a host controller drives to an SD card. It takes a fixed base clock and divides it by a power of two, or passes it through undivided. A 16-bit clock-control register sets the divisor through a one-hot select field and turns the clock on or off with an enable bit. When the card is removed, the block clears the enable bit by itself.

The card clock never glitches. It starts low and its first edge is a rising one. When software disables it, the clock finishes any high phase in progress and then holds low. The divisor is captured at the moment the clock goes from stopped to running. Software may rewrite the select field while the clock runs and reads back the new value, but the frequency in use stays the same until the next restart. Software reaches the register through a write port with per-byte enables and a read-back bus that is always valid.

Top module: `sdclk_gen`

## Requirements
- R1: After reset the register reads 0x0000 and the card clock is low.
- R2: A select code of 0x00 gives the base clock undivided. A code with only bit k (0..7) set divides the base clock by 2^(k+1), so 0x01 gives /2 and 0x80 gives /256.
- R3: When more than one select bit is set, only the most significant set bit picks the divisor.
- R4: A divided clock spends exactly N/2 base cycles high and N/2 base cycles low, where N is the divisor.
- R5: When the clock is enabled from the stopped state, the output is low first. The first rising edge appears 1 + N/2 base cycles after the enabling write (2 cycles in pass-through), with no runt pulse.
- R6: Writing the enable bit to 0 stops the clock at a low level. A high phase already in progress completes its full N/2 cycles before the output holds low.
- R7: Writes to the select field while the clock runs are stored and read back, but the running frequency does not change until the clock is stopped and enabled again.
- R8: The card-present input passes through a two-flop synchronizer. The enable bit is cleared 3 base cycles after card-present falls. While the card is absent, a write that sets the enable bit has no effect.
- R9: Register layout: bits [15:8] hold the select field, bit [2] is the enable bit (1 = running, 0 = stopped), and all other bits read as 0.
- R10: Write byte enable bit 1 updates bits [15:8] only. Byte enable bit 0 updates bits [7:0] only, which means just the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base | input | 1 | Base clock; also the undivided source |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte enables: [1] select byte, [0] control byte |
| wr_data | input | 16 | Write data |
| card_present | input | 1 | Card-detect level, asynchronous, 1 = card inserted |
| sd_clk | output | 1 | Gated, divided card clock |
| rd_data | output | 16 | Register read-back |

## Verification
The bench goes after the edges of the divisor map: pass-through at code 0, which a purely counter-based design could not produce, and /256 at the top bit, where an undersized counter would wrap and give a short period. It also drives multi-bit codes, where a design that picks the lowest set bit would run far too fast. It disables the clock in mid high phase, which catches a gate that would cut the high pulse short. It rewrites the select field while the clock runs, which exposes a design that re-reads the field on the fly and changes frequency mid-stream. It also removes the card and then tries to set the enable bit, which exposes a clear that is too early, too late, or loses to a software write.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  localparam int SD_REG_W   = 16;
  localparam int SD_FIELD_W = 8;
  localparam int SD_EN_POS  = 2;
  localparam int SD_SYNC_N  = 2;

  typedef enum logic {
    RUN_IDLE = 1'b0,
    RUN_ON   = 1'b1
  } run_state_t;

endpackage

// File: rtl/sdclk_sync.sv
module sdclk_sync #(
  parameter int STAGES = sdclk_pkg::SD_SYNC_N
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= 1'b0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/sdclk_ctrl_reg.sv
module sdclk_ctrl_reg #(
  parameter int REG_W   = sdclk_pkg::SD_REG_W,
  parameter int FIELD_W = sdclk_pkg::SD_FIELD_W,
  parameter int EN_POS  = sdclk_pkg::SD_EN_POS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_be,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               card_ok,
  output logic [FIELD_W-1:0] sel_field,
  output logic               en_bit,
  output logic [REG_W-1:0]   rd_data
);

  localparam int SEL_LSB = REG_W - FIELD_W;

  logic wr_sel_byte;
  logic wr_ctl_byte;
  logic unused_wr_bits;

  assign wr_sel_byte = wr_en && wr_be[1];
  assign wr_ctl_byte = wr_en && wr_be[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_field <= '0;
    end else if (wr_sel_byte) begin
      sel_field <= wr_data[REG_W-1:SEL_LSB];
    end
  end

  // Card removal outranks any software write to the enable bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_bit <= 1'b0;
    end else if (!card_ok) begin
      en_bit <= 1'b0;
    end else if (wr_ctl_byte) begin
      en_bit <= wr_data[EN_POS];
    end
  end

  always_comb begin
    rd_data                     = '0;
    rd_data[REG_W-1:SEL_LSB]    = sel_field;
    rd_data[EN_POS]             = en_bit;
  end

  assign unused_wr_bits = ^{wr_data[SEL_LSB-1:EN_POS+1], wr_data[EN_POS-1:0]};

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
  import sdclk_pkg::*;
#(
  parameter int FIELD_W = SD_FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_bit,
  input  logic [FIELD_W-1:0] sel_field,
  output logic               sd_clk,
  output logic               running,
  output logic               div_q,
  output logic [FIELD_W-1:0] half_in_use
);

  localparam int CNT_W = FIELD_W;

  // Half period in base cycles for a select code; 0 marks pass-through.
  function automatic logic [CNT_W-1:0] half_of(input logic [FIELD_W-1:0] code);
    logic [CNT_W-1:0] h;
    h = '0;
    for (int k = FIELD_W - 1; k >= 0; k--) begin
      if (code[k] && (h == '0)) h = CNT_W'(1) << k;
    end
    return h;
  endfunction

  run_state_t       state_q;
  logic [CNT_W-1:0] half_q;
  logic [CNT_W-1:0] cnt_q;
  logic             q_q;
  logic             bypass;
  logic             phase_end;
  logic             stop_now;
  logic             gate_n;

  assign bypass    = (half_q == '0);
  assign phase_end = (cnt_q == half_q - CNT_W'(1));
  assign stop_now  = !en_bit && !q_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RUN_IDLE;
      half_q  <= '0;
      cnt_q   <= '0;
      q_q     <= 1'b0;
    end else if (state_q == RUN_IDLE) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
      if (en_bit) begin
        state_q <= RUN_ON;
        half_q  <= half_of(sel_field);
      end
    end else if (stop_now) begin
      state_q <= RUN_IDLE;
    end else if (!bypass) begin
      if (phase_end) begin
        cnt_q <= '0;
        q_q   <= ~q_q;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // Pass-through gate changes only while the base clock is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_n <= 1'b0;
    else        gate_n <= (state_q == RUN_ON) && bypass;
  end

  assign sd_clk      = bypass ? (clk & gate_n) : q_q;
  assign running     = (state_q == RUN_ON);
  assign div_q       = q_q;
  assign half_in_use = half_q;

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
  import sdclk_pkg::*;
#(
  parameter int REG_W   = SD_REG_W,
  parameter int FIELD_W = SD_FIELD_W,
  parameter int EN_POS  = SD_EN_POS,
  parameter int SYNC_N  = SD_SYNC_N
) (
  input  logic             clk_base,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_be,
  input  logic [REG_W-1:0] wr_data,
  input  logic             card_present,
  output logic             sd_clk,
  output logic [REG_W-1:0] rd_data
);

  logic               card_ok;
  logic               en_bit;
  logic [FIELD_W-1:0] sel_field;
  logic               running;
  logic               div_q;
  logic [FIELD_W-1:0] half_in_use;

  sdclk_sync #(.STAGES(SYNC_N)) u_sync (
    .clk     (clk_base),
    .rst_n   (rst_n),
    .d_async (card_present),
    .q_sync  (card_ok)
  );

  sdclk_ctrl_reg #(
    .REG_W   (REG_W),
    .FIELD_W (FIELD_W),
    .EN_POS  (EN_POS)
  ) u_reg (
    .clk       (clk_base),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_be     (wr_be),
    .wr_data   (wr_data),
    .card_ok   (card_ok),
    .sel_field (sel_field),
    .en_bit    (en_bit),
    .rd_data   (rd_data)
  );

  sdclk_divider #(.FIELD_W(FIELD_W)) u_div (
    .clk         (clk_base),
    .rst_n       (rst_n),
    .en_bit      (en_bit),
    .sel_field   (sel_field),
    .sd_clk      (sd_clk),
    .running     (running),
    .div_q       (div_q),
    .half_in_use (half_in_use)
  );

endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk #(
  parameter int FIELD_W = 8
) (
  input logic               clk_base,
  input logic               rst_n,
  input logic               wr_en,
  input logic [1:0]         wr_be,
  input logic               card_ok,
  input logic               en_bit,
  input logic [FIELD_W-1:0] sel_field,
  input logic               running,
  input logic               div_q,
  input logic [FIELD_W-1:0] half_in_use
);

  // R6: a stopped divider holds its output low
  p_idle_low_r6: assert property (@(posedge clk_base) disable iff (!rst_n)
    !running |-> !div_q);

  // R6: a high phase is never cut short by a disable
  p_keep_high_r6: assert property (@(posedge clk_base) disable iff (!rst_n)
    (running && div_q && !en_bit) |=> running);

  // R5: the clock leaves the stopped state from a low level
  p_start_low_r5: assert property (@(posedge clk_base) disable iff (!rst_n)
    $rose(running) |-> !div_q);

  // R7: the captured divisor stays fixed while the clock runs
  p_frozen_r7: assert property (@(posedge clk_base) disable iff (!rst_n)
    running |=> (!running || $stable(half_in_use)));

  // R8: an absent card forces the enable bit to clear
  p_autoclear_r8: assert property (@(posedge clk_base) disable iff (!rst_n)
    !card_ok |=> !en_bit);

  // R10: the select field moves only on a write with byte enable 1
  p_field_hold_r10: assert property (@(posedge clk_base) disable iff (!rst_n)
    !(wr_en && wr_be[1]) |=> $stable(sel_field));

endmodule

bind sdclk_gen sdclk_gen_chk #(.FIELD_W(FIELD_W)) u_chk (
  .clk_base    (clk_base),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_be       (wr_be),
  .card_ok     (card_ok),
  .en_bit      (en_bit),
  .sel_field   (sel_field),
  .running     (running),
  .div_q       (div_q),
  .half_in_use (half_in_use)
);

// File: tb/sdclk_gen_tb.sv
module sdclk_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_be = 2'b00;
  logic [15:0] wr_data = 16'h0000;
  logic        card_present = 1'b1;
  logic        sd_clk;
  logic [15:0] rd_data;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #2.5 clk = ~clk;

  sdclk_gen u_dut (
    .clk_base     (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_be        (wr_be),
    .wr_data      (wr_data),
    .card_present (card_present),
    .sd_clk       (sd_clk),
    .rd_data      (rd_data)
  );

  // Divisor implied by a select code: the highest set bit k gives 2^(k+1)
  function automatic int exp_div(input logic [7:0] code);
    int n;
    n = 1;
    for (int k = 0; k < 8; k++) if (code[k]) n = 2 << k;
    return n;
  endfunction

  function automatic int exp_first_rise(input int n);
    return (n == 1) ? 2 : 1 + n / 2;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic reg_write(input logic [1:0] be, input logic [15:0] d);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    tick();
    wr_en = 1'b0; wr_be = 2'b00; wr_data = 16'h0000;
  endtask

  task automatic wait_rise(input int limit, output int idx);
    idx = -1;
    for (int i = 1; i <= limit; i++) begin
      tick();
      if (sd_clk) begin idx = i; break; end
    end
  endtask

  task automatic count_level(input logic lvl, input int limit, output int len);
    len = 1;
    for (int i = 0; i < limit; i++) begin
      tick();
      if (sd_clk !== lvl) break;
      len++;
    end
  endtask

  task automatic stop_and_settle(input int n);
    int lows;
    reg_write(2'b01, 16'h0000);
    repeat (n + 4) tick();
    lows = 0;
    for (int i = 0; i < 2 * n + 4; i++) begin
      tick();
      if (!sd_clk) lows++;
    end
    check(lows == 2 * n + 4, "R6 stopped low", lows, 2 * n + 4);
  endtask

  task automatic run_code(input logic [7:0] code);
    int n, idx, hi, lo, ones;
    string tag;
    n = exp_div(code);
    ones = $countones(code);
    tag = (ones > 1) ? "R3 msb wins" : "R2 divisor";
    reg_write(2'b10, {code, 8'h00});
    reg_write(2'b01, 16'h0004);
    check(sd_clk == 1'b0, "R5 low at enable", sd_clk, 0);
    wait_rise(n + 8, idx);
    check(idx == exp_first_rise(n), "R5 first rise", idx, exp_first_rise(n));
    if (n == 1) begin
      count_level(1'b1, 8, hi);
      check(hi == 9, {tag, " pass-through"}, hi, 9);
    end else begin
      count_level(1'b1, n + 4, hi);
      check(hi == n / 2, {tag, " R4 high"}, hi, n / 2);
      count_level(1'b0, n + 4, lo);
      check(lo == n / 2, {tag, " R4 low"}, lo, n / 2);
    end
    stop_and_settle(n);
  endtask

  initial begin
    int idx, hi;
    logic [7:0] code;
    void'($urandom(32'd2024));
    repeat (3) tick();
    check(rd_data == 16'h0000, "R1 reg reset", rd_data, 0);
    check(sd_clk == 1'b0, "R1 clock reset", sd_clk, 0);
    rst_n = 1'b1;
    repeat (4) tick();
    check(rd_data == 16'h0000, "R1 reg after release", rd_data, 0);

    // R10 and R9: byte lanes and reserved bits
    reg_write(2'b10, 16'hA5FF);
    check(rd_data == 16'hA500, "R10 select lane only", rd_data, 16'hA500);
    reg_write(2'b01, 16'h3CFF);
    check(rd_data == 16'hA504, "R9 R10 control lane", rd_data, 16'hA504);
    stop_and_settle(256);
    reg_write(2'b11, 16'h0000);
    check(rd_data == 16'h0000, "R10 both lanes", rd_data, 0);

    // R2: every legal code, both ends included
    run_code(8'h00);
    for (int k = 0; k < 8; k++) run_code(8'h01 << k);
    // R3: multi-bit codes
    run_code(8'h0C);
    run_code(8'hFF);
    run_code(8'h81);

    // R6: disable in mid high phase (divisor 16)
    reg_write(2'b10, 16'h0800);
    reg_write(2'b01, 16'h0004);
    wait_rise(30, idx);
    hi = 1;
    tick(); if (sd_clk) hi++;
    tick(); if (sd_clk) hi++;
    reg_write(2'b01, 16'h0000);
    if (sd_clk) hi++;
    while (sd_clk && hi < 40) begin tick(); if (sd_clk) hi++; end
    check(hi == 8, "R6 high phase completes", hi, 8);
    hi = 0;
    for (int i = 0; i < 40; i++) begin tick(); if (sd_clk) hi++; end
    check(hi == 0, "R6 holds low", hi, 0);

    // R7: select rewrite while running
    reg_write(2'b10, 16'h0400);
    reg_write(2'b01, 16'h0004);
    reg_write(2'b10, 16'h8000);
    check(rd_data == 16'h8004, "R7 read-back of new field", rd_data, 16'h8004);
    wait_rise(20, idx);
    count_level(1'b1, 300, hi);
    check(hi == 4, "R7 frequency frozen", hi, 4);
    stop_and_settle(8);
    reg_write(2'b01, 16'h0004);
    wait_rise(200, idx);
    check(idx == 129, "R7 new divisor after restart", idx, 129);
    stop_and_settle(256);

    // R8: card removal
    reg_write(2'b10, 16'h0100);
    reg_write(2'b01, 16'h0004);
    card_present = 1'b0;
    tick(); tick();
    check(rd_data[2] == 1'b1, "R8 sync latency", rd_data[2], 1);
    tick();
    check(rd_data[2] == 1'b0, "R8 auto clear", rd_data[2], 0);
    repeat (6) tick();
    hi = 0;
    for (int i = 0; i < 12; i++) begin tick(); if (sd_clk) hi++; end
    check(hi == 0, "R8 clock stopped", hi, 0);
    reg_write(2'b01, 16'h0004);
    check(rd_data[2] == 1'b0, "R8 clear beats write", rd_data[2], 0);
    card_present = 1'b1;
    repeat (3) tick();
    reg_write(2'b01, 16'h0004);
    check(rd_data[2] == 1'b1, "R8 enable after reinsert", rd_data[2], 1);
    stop_and_settle(4);

    // Random codes, weighted toward single-bit ones
    for (int it = 0; it < 24; it++) begin
      code = 8'($urandom);
      if ($urandom % 3 == 0) code = 8'h01 << ($urandom % 8);
      run_code(code);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule